// File: doc/BRIEF.md
# Fractional-Divisor UART Baud Tick Generator

This block produces the 16x oversampling strobe that clocks the receiver and transmitter of a 16550-class UART. The rate is set by a divisor with two parts. One part is a 16-bit whole number of input clocks. The other is a fraction of FRAC_W bits, where FRAC_W is an elaboration-time parameter of 4, 5 or 6. The intended setting is divisor = f_clk / (16 × baud), and the effective divisor is DIV + FRAC / 2^FRAC_W.

The fraction is applied by dithering. At the start of each tick period, a FRAC_W-bit phase accumulator adds the fraction. A carry out of that addition lengthens the current period by one clock. Over 2^FRAC_W consecutive periods the error therefore cancels exactly. A fraction of zero gives plain integer division.

A byte-wide register port holds the two divisor latch bytes and the fraction register. Every register can be read back. Software can find FRAC_W by writing all ones to the fraction register and reading it back: only the implemented low bits return ones. Any write to one of the three registers restarts the period counter and clears the accumulator, so the new rate starts cleanly.

Top module: `frac_baud_gen`

## Requirements
- R1: After synchronous reset the divisor-low (address 0x00), divisor-high (0x01) and fraction (0xC0) registers read 0, and tick_o stays low.
- R2: Writing a byte to address 0xC0 stores its low FRAC_W bits; a read of 0xC0 returns those bits with every bit at FRAC_W and above reading 0, so writing 0xFF reads back 2^FRAC_W-1.
- R3: The 16-bit integer divisor takes bits 7:0 from writes to 0x00 and bits 15:8 from writes to 0x01, and each byte reads back at its own address; read data appears on bus_rdata one clock after bus_addr is presented.
- R4: While the integer divisor is 0, tick_o never asserts, whatever the fraction.
- R5: With fraction 0 and integer divisor D ≥ 1, ticks come exactly every D clocks.
- R6: Counting tick p = 1, 2, ... after the last register write, tick p is seen p·D + floor(p·F / 2^FRAC_W) clocks after the write edge, so every period is D or D+1 clocks.
- R7: Any 2^FRAC_W consecutive periods starting right after a register write span exactly D·2^FRAC_W + F clocks.
- R8: A write to 0x00, 0x01 or 0xC0 restarts the period counter and clears the accumulator; the first tick after it arrives exactly D clocks after the write edge, with no tick in between.
- R9: tick_o is a one-clock pulse whenever D ≥ 2.
- R10: Writes to any other address change no register and do not restart; reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that is divided |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe, one byte per clock |
| bus_addr | input | 8 | Register address for read and write |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| tick_o | output | 1 | 16x oversampling strobe, one clock wide |

## Verification
A wrong accumulator value or a lost carry shows up at tick_o as a tick one clock early or late. It appears within the first 2^FRAC_W periods after a write, because the tick times from the write follow a closed form that the bench computes for every tick. A counter that is not cleared on restart moves the first tick away from exactly D clocks after the write edge. A bad register slice or readback mux shows up on the next read, one clock after the address is presented. The bench sweeps every fraction value against several small divisors, so each carry pattern is seen.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

  localparam int unsigned BUS_ADDR_W = 8;
  localparam int unsigned BUS_DATA_W = 8;

  localparam logic [BUS_ADDR_W-1:0] ADR_DIV_LO = 8'h00;
  localparam logic [BUS_ADDR_W-1:0] ADR_DIV_HI = 8'h01;
  localparam logic [BUS_ADDR_W-1:0] ADR_FRAC   = 8'hC0;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_DIV_LO,
    SEL_DIV_HI,
    SEL_FRAC
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [BUS_ADDR_W-1:0] a);
    case (a)
      ADR_DIV_LO: return SEL_DIV_LO;
      ADR_DIV_HI: return SEL_DIV_HI;
      ADR_FRAC:   return SEL_FRAC;
      default:    return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import frac_baud_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned FRAC_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [BUS_ADDR_W-1:0] addr,
  input  logic [BUS_DATA_W-1:0] wdata,
  output logic [BUS_DATA_W-1:0] rdata,
  output logic [DIV_W-1:0]      div_o,
  output logic [FRAC_W-1:0]     frac_o,
  output logic                  restart_o
);

  localparam int unsigned HI_W = DIV_W - BUS_DATA_W;

  reg_sel_e              sel;
  logic [DIV_W-1:0]      div_q;
  logic [FRAC_W-1:0]     frac_q;
  logic [BUS_DATA_W-1:0] rdata_d;
  logic [BUS_DATA_W-1:0] rdata_q;

  assign sel       = decode_addr(addr);
  assign restart_o = we && (sel != SEL_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      frac_q <= '0;
    end else if (we) begin
      case (sel)
        SEL_DIV_LO: div_q[BUS_DATA_W-1:0]   <= wdata;
        SEL_DIV_HI: div_q[DIV_W-1:BUS_DATA_W] <= wdata[HI_W-1:0];
        SEL_FRAC:   frac_q                  <= wdata[FRAC_W-1:0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_DIV_LO: rdata_d = div_q[BUS_DATA_W-1:0];
      SEL_DIV_HI: rdata_d[HI_W-1:0] = div_q[DIV_W-1:BUS_DATA_W];
      SEL_FRAC:   rdata_d[FRAC_W-1:0] = frac_q;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rdata_d;
  end

  assign rdata  = rdata_q;
  assign div_o  = div_q;
  assign frac_o = frac_q;

endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac,
  output logic              extra_o,
  output logic [FRAC_W-1:0] acc_o
);

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  // Carry of the add that belongs to the period now running.
  assign sum     = {1'b0, acc_q} + {1'b0, frac};
  assign extra_o = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (rst || restart) acc_q <= '0;
    else if (step)      acc_q <= sum[FRAC_W-1:0];
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/baud_tick_counter.sv
module baud_tick_counter #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  input  logic             extra,
  output logic             end_o,
  output logic             tick_o,
  output logic [DIV_W-1:0] cnt_o
);

  localparam int unsigned EXT_W = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q;
  logic [EXT_W-1:0] limit;
  logic [EXT_W-1:0] cnt_inc;
  logic             run;
  logic             tick_q;

  assign run     = (div != '0);
  assign limit   = {1'b0, div} + {{DIV_W{1'b0}}, extra};
  assign cnt_inc = {1'b0, cnt_q} + {{DIV_W{1'b0}}, 1'b1};
  assign end_o   = run && (cnt_inc == limit);

  always_ff @(posedge clk) begin
    if (rst || restart)   cnt_q <= '0;
    else if (!run)        cnt_q <= '0;
    else if (end_o)       cnt_q <= '0;
    else                  cnt_q <= cnt_inc[DIV_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || restart) tick_q <= 1'b0;
    else                tick_q <= end_o;
  end

  assign tick_o = tick_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned FRAC_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_we,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       tick_o
);

  logic [DIV_W-1:0]  div_q;
  logic [FRAC_W-1:0] frac_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic              restart;
  logic              period_end;
  logic              extra;

  baud_regs #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (bus_we),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .div_o     (div_q),
    .frac_o    (frac_q),
    .restart_o (restart)
  );

  baud_phase_acc #(.FRAC_W(FRAC_W)) i_acc (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .step    (period_end),
    .frac    (frac_q),
    .extra_o (extra),
    .acc_o   (acc_q)
  );

  baud_tick_counter #(.DIV_W(DIV_W)) i_cnt (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .div     (div_q),
    .extra   (extra),
    .end_o   (period_end),
    .tick_o  (tick_o),
    .cnt_o   (cnt_q)
  );

endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned FRAC_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              tick_o,
  input logic              restart,
  input logic [DIV_W-1:0]  div_q,
  input logic [DIV_W-1:0]  cnt_q,
  input logic [FRAC_W-1:0] acc_q
);

  AST_TICK_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    (tick_o && (div_q > 1)) |=> !tick_o); // R9

  AST_NO_TICK_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (div_q == '0) |=> !tick_o); // R4

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    restart |=> ((cnt_q == '0) && (acc_q == '0))); // R8

  AST_FRAC_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 8'hC0) |=> ((bus_rdata >> FRAC_W) == 8'h00)); // R2

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (div_q != '0) |-> (cnt_q <= div_q)); // R6

endmodule

bind frac_baud_gen frac_baud_gen_chk #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .tick_o    (tick_o),
  .restart   (restart),
  .div_q     (div_q),
  .cnt_q     (cnt_q),
  .acc_q     (acc_q)
);

// File: tb/test_frac_baud_gen.sv
`timescale 1ns/1ps
module test_frac_baud_gen;

  localparam int FRAC_W = 4;
  localparam int FR_MOD = 1 << FRAC_W;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tick_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  frac_baud_gen #(.DIV_W(16), .FRAC_W(FRAC_W)) i_frac_baud_gen (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick_o    (tick_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a[7:0]; bus_wdata = d[7:0];
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    bus_addr = a[7:0];
    @(negedge clk);
    v = int'(bus_rdata);
    bus_addr = 8'h00;
  endtask

  // Programs D and F, then checks tick times against p*D + floor(p*F/2^W).
  task automatic run_cfg(input int dv, input int fr, input int nt);
    int t = 0;
    int p = 0;
    int mism = 0;
    int bad_act = 0;
    int bad_exp = 0;
    int span = -1;
    int first_t = -1;
    int limit = nt * (dv + 1) + 4;
    wr(8'h00, dv & 255);
    wr(8'h01, dv >> 8);
    wr(8'hC0, fr);
    while (p < nt && t < limit) begin
      @(negedge clk);
      t++;
      if (tick_o) begin
        int e;
        p++;
        e = p * dv + (p * fr) / FR_MOD;
        if (p == 1) first_t = t;
        if (t != e) begin
          if (mism == 0) begin bad_act = t; bad_exp = e; end
          mism++;
        end
        if (p == FR_MOD) span = t;
      end
    end
    check("R8 first tick after write", first_t, dv);
    if (fr == 0) check("R5 integer-only tick time", bad_act, bad_exp);
    else         check("R6 dithered tick time", bad_act, bad_exp);
    check("R6 tick count", p, nt);
    if (nt >= FR_MOD) check("R7 span of 2^W periods", span, dv * FR_MOD + fr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    int seen;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tick_o) seen++;
    end
    check("R1 no tick after reset", seen, 0);
    rd(8'h00, v); check("R1 divisor low reset", v, 0);
    rd(8'h01, v); check("R1 divisor high reset", v, 0);
    rd(8'hC0, v); check("R1 fraction reset", v, 0);

    // R2 fraction width discovery
    wr(8'hC0, 8'hFF); rd(8'hC0, v); check("R2 all-ones readback", v, FR_MOD - 1);
    wr(8'hC0, 8'hA5); rd(8'hC0, v); check("R2 masked readback", v, 8'hA5 & (FR_MOD - 1));

    // R3 divisor bytes
    wr(8'h00, 8'h34); wr(8'h01, 8'h12);
    rd(8'h00, v); check("R3 divisor low", v, 8'h34);
    rd(8'h01, v); check("R3 divisor high", v, 8'h12);

    // R10 unmapped addresses
    wr(8'h02, 8'h55); wr(8'h80, 8'hAA); wr(8'hC1, 8'h0F);
    rd(8'h00, v); check("R10 low unchanged", v, 8'h34);
    rd(8'h01, v); check("R10 high unchanged", v, 8'h12);
    rd(8'hC0, v); check("R10 fraction unchanged", v, 8'hA5 & (FR_MOD - 1));
    rd(8'h02, v); check("R10 unmapped reads zero", v, 0);
    rd(8'hC1, v); check("R10 neighbour reads zero", v, 0);

    // R4 zero divisor halts ticks
    wr(8'h00, 0); wr(8'h01, 0); wr(8'hC0, 9);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (tick_o) seen++;
    end
    check("R4 ticks with divisor zero", seen, 0);

    // R8 restart in mid period
    wr(8'h00, 9); wr(8'h01, 0); wr(8'hC0, 0);
    repeat (13) @(negedge clk);
    wr(8'hC0, 3);
    v = 0; seen = 0;
    while (seen == 0 && v < 40) begin
      @(negedge clk); v++;
      if (tick_o) seen = 1;
    end
    check("R8 mid-period restart", v, 9);

    // R5 R6 R7 R9 exhaustive fraction sweep on small divisors
    for (int di = 0; di < 4; di++) begin
      int dv;
      case (di)
        0: dv = 1;
        1: dv = 2;
        2: dv = 3;
        default: dv = 7;
      endcase
      for (int fr = 0; fr < FR_MOD; fr++) run_cfg(dv, fr, 2 * FR_MOD);
    end

    // Divisor using the high byte
    run_cfg(300, 11, FR_MOD + 2);
    run_cfg(258, FR_MOD - 1, FR_MOD);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule